// File: doc/BRIEF.md
# Phase-Encoded Dual-Rail Logic Gate

This block is a two-input logic cell for a delay-insensitive four-state logic. Every signal is a pair of rails, `a` and `b`. Together the rails carry a logic value and a phase that alternates between 0 and 1. The cell stores its output pair. It replaces that pair only when both input pairs are in the same phase. The new output is the selected logic function (AND, OR or XOR) of the two input values, encoded in the phase the inputs share. An inconsistent input vector, meaning one whose inputs differ in phase, leaves the stored output as it is.

The model is clocked. Each rising clock edge stands for one evaluation step of the asynchronous cell. Around the gate core the block provides three test aids:
- a phase inverter applied to the stored output;
- a converter that turns a plain bit plus a requested phase into a rail pair;
- decoded value and phase outputs for the stored pair.

These let a plain-logic environment drive and observe the cell.

Top module: `dualrail_phase_gate`

## Requirements
- R1: The four rail codes `{a,b}` are: H=11 (value 1, phase 1), L=00 (value 0, phase 1), h=10 (value 1, phase 0) and l=01 (value 0, phase 0). The output `q_val` equals `q_a`, and `q_ph` equals `q_a XNOR q_b`.
- R2: If both input pairs have the same phase and the opcode is valid, `{q_a,q_b}` after the next rising edge is the function result encoded in that common phase.
- R3: If the two input pairs differ in phase, `{q_a,q_b}` keeps its value across the edge, whatever the opcode.
- R4: The opcode values are 2'b00 AND, 2'b01 OR and 2'b10 XOR. Opcode 2'b11 is reserved and leaves `{q_a,q_b}` unchanged at the edge.
- R5: `{qinv_a,qinv_b}` equals `{q_a, ~q_b}`. This keeps the value and toggles the phase of the stored output.
- R6: A synchronous active-high `rst` sets `{q_a,q_b}` to l (2'b01) at the edge. It takes priority over any evaluation in the same cycle.
- R7: The converter sets `enc_a` to `plain_d` and `enc_b` to `~(plain_d ^ plain_ph)`, so the pair decodes to value `plain_d` and phase `plain_ph`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Evaluation step clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Function select |
| x_a | input | 1 | Input X, rail a |
| x_b | input | 1 | Input X, rail b |
| y_a | input | 1 | Input Y, rail a |
| y_b | input | 1 | Input Y, rail b |
| q_a | output | 1 | Stored output, rail a |
| q_b | output | 1 | Stored output, rail b |
| q_val | output | 1 | Decoded value of the stored output |
| q_ph | output | 1 | Decoded phase of the stored output |
| qinv_a | output | 1 | Phase-inverted output, rail a |
| qinv_b | output | 1 | Phase-inverted output, rail b |
| plain_d | input | 1 | Plain data bit to convert |
| plain_ph | input | 1 | Requested phase for conversion |
| enc_a | output | 1 | Converted pair, rail a |
| enc_b | output | 1 | Converted pair, rail b |

## Verification
Reset and a phase-consistent evaluation can fall in the same cycle. The bench provokes this by holding `rst` high while both inputs carry H under OR, which on its own would produce H. It judges the result by requiring the stored pair to read l after that edge, and H only after the following edge once `rst` is released. Holding on a phase mismatch also meets an opcode change in the same cycle. The bench judges that case by requiring the stored pair to be unchanged.

// File: rtl/dr_pkg.sv
package dr_pkg;

  typedef struct packed {
    logic a;
    logic b;
  } dr_pair_t;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_XOR = 2'b10,
    OP_RSV = 2'b11
  } dr_op_e;

  localparam int unsigned NUM_IN = 2;
  localparam dr_pair_t DR_RESET = '{a: 1'b0, b: 1'b1};

  // phase 1 when both rails agree
  function automatic logic dr_phase(input dr_pair_t p);
    return ~(p.a ^ p.b);
  endfunction

  function automatic logic dr_value(input dr_pair_t p);
    return p.a;
  endfunction

  function automatic dr_pair_t dr_encode(input logic v, input logic ph);
    dr_pair_t r;
    r.a = v;
    r.b = v ^ ~ph;
    return r;
  endfunction

  function automatic logic dr_op_valid(input logic [1:0] op);
    return op != OP_RSV;
  endfunction

  function automatic logic dr_func(input logic [1:0] op, input logic vx, input logic vy);
    logic r;
    case (dr_op_e'(op))
      OP_AND:  r = vx & vy;
      OP_OR:   r = vx | vy;
      OP_XOR:  r = vx ^ vy;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dr_decoder.sv
module dr_decoder
  import dr_pkg::*;
(
  input  dr_pair_t pair,
  output logic     val,
  output logic     ph
);
  assign val = dr_value(pair);
  assign ph  = dr_phase(pair);
endmodule

// File: rtl/dr_encoder.sv
module dr_encoder
  import dr_pkg::*;
(
  input  logic     d,
  input  logic     ph,
  output dr_pair_t pair
);
  assign pair = dr_encode(d, ph);

  // R7: the produced pair decodes back to the requested bit and phase
  always_comb begin
    if (!$isunknown({d, ph})) begin
      a_conv_roundtrip_r7: assert ((pair.a == pair.b) == ph && pair.a == d)
        else $error("R7 converter round trip broken");
    end
  end
endmodule

// File: rtl/dr_phase_inv.sv
module dr_phase_inv
  import dr_pkg::*;
(
  input  dr_pair_t pin,
  output dr_pair_t pout
);
  assign pout.a = pin.a;
  assign pout.b = ~pin.b;
endmodule

// File: rtl/dr_eval_core.sv
module dr_eval_core
  import dr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] op,
  input  dr_pair_t   x,
  input  dr_pair_t   y,
  output dr_pair_t   q,
  output logic       evt_match,
  output logic       evt_update
);
  dr_pair_t ins [NUM_IN];
  logic     vals [NUM_IN];
  logic     phs  [NUM_IN];

  assign ins[0] = x;
  assign ins[1] = y;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_dec
    dr_decoder u_dec (.pair(ins[i]), .val(vals[i]), .ph(phs[i]));
  end

  logic     common_ph;
  dr_pair_t next_q;

  assign evt_match  = (phs[0] == phs[1]);
  assign evt_update = evt_match && dr_op_valid(op);
  assign common_ph  = phs[0];
  assign next_q     = dr_encode(dr_func(op, vals[0], vals[1]), common_ph);

  always_ff @(posedge clk) begin
    if (rst)             q <= DR_RESET;
    else if (evt_update) q <= next_q;
  end

  p_reset_low_r6: assert property (@(posedge clk) rst |=> (q.a == 1'b0 && q.b == 1'b1))
    else $error("R6 reset code not l");

  p_hold_mismatch_r3: assert property (@(posedge clk) disable iff (rst)
    !evt_match |=> $stable(q))
    else $error("R3 output moved on phase mismatch");

  p_rsv_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RSV) |=> $stable(q))
    else $error("R4 reserved opcode changed output");

  p_phase_follow_r2: assert property (@(posedge clk) disable iff (rst)
    evt_update |=> ((q.a == q.b) == $past(x.a == x.b)))
    else $error("R2 output phase does not follow inputs");
endmodule

// File: rtl/dualrail_phase_gate.sv
module dualrail_phase_gate
  import dr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] op,
  input  logic       x_a,
  input  logic       x_b,
  input  logic       y_a,
  input  logic       y_b,
  output logic       q_a,
  output logic       q_b,
  output logic       q_val,
  output logic       q_ph,
  output logic       qinv_a,
  output logic       qinv_b,
  input  logic       plain_d,
  input  logic       plain_ph,
  output logic       enc_a,
  output logic       enc_b
);
  dr_pair_t x_p, y_p, q_p, qinv_p, enc_p;
  logic     evt_match, evt_update;

  assign x_p = '{a: x_a, b: x_b};
  assign y_p = '{a: y_a, b: y_b};

  dr_eval_core u_core (
    .clk(clk), .rst(rst), .op(op), .x(x_p), .y(y_p),
    .q(q_p), .evt_match(evt_match), .evt_update(evt_update)
  );

  dr_phase_inv u_pinv (.pin(q_p), .pout(qinv_p));

  dr_pair_t obs   [2];
  logic     o_val [2];
  logic     o_ph  [2];
  assign obs[0] = q_p;
  assign obs[1] = qinv_p;

  for (genvar i = 0; i < 2; i++) begin : g_obs
    dr_decoder u_odec (.pair(obs[i]), .val(o_val[i]), .ph(o_ph[i]));
  end

  dr_encoder u_enc (.d(plain_d), .ph(plain_ph), .pair(enc_p));

  assign q_a    = q_p.a;
  assign q_b    = q_p.b;
  assign q_val  = o_val[0];
  assign q_ph   = o_ph[0];
  assign qinv_a = qinv_p.a;
  assign qinv_b = qinv_p.b;
  assign enc_a  = enc_p.a;
  assign enc_b  = enc_p.b;

  p_inv_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (o_val[1] == o_val[0]) && (o_ph[1] != o_ph[0]))
    else $error("R5 inverter changed value or kept phase");
endmodule

// File: tb/sim_dualrail_phase_gate.sv
module sim_dualrail_phase_gate;
  localparam int CLK_P = 10;
  // code table: L, H, l, h as {a,b}
  localparam logic [1:0] CODES [4] = '{2'b00, 2'b11, 2'b01, 2'b10};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] op = 2'b00;
  logic x_a = 0, x_b = 1, y_a = 0, y_b = 1;
  logic q_a, q_b, q_val, q_ph, qinv_a, qinv_b;
  logic plain_d = 0, plain_ph = 0;
  logic enc_a, enc_b;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [1:0] model;

  always #(CLK_P/2) clk = ~clk;

  dualrail_phase_gate u0 (
    .clk(clk), .rst(rst), .op(op), .x_a(x_a), .x_b(x_b), .y_a(y_a), .y_b(y_b),
    .q_a(q_a), .q_b(q_b), .q_val(q_val), .q_ph(q_ph), .qinv_a(qinv_a),
    .qinv_b(qinv_b), .plain_d(plain_d), .plain_ph(plain_ph),
    .enc_a(enc_a), .enc_b(enc_b)
  );

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [1:0] tb_pair(input logic v, input logic ph);
    return {v, ph ? v : ~v};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_outputs(input string req);
    chk(req, {q_a, q_b}, model);
    chk("R1", {q_val, q_ph}, {model[1], model[1] == model[0]});
    chk("R5", {qinv_a, qinv_b}, {model[1], ~model[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    step();
    step();
    model = 2'b01;
    check_outputs("R6");
    rst = 1'b0;

    for (int o = 0; o < 4; o++) begin
      for (int i = 0; i < 16; i++) begin
        logic [1:0] cx, cy;
        logic vx, vy, px, py, r;
        string tag;
        cx = CODES[i / 4];
        cy = CODES[i % 4];
        op = 2'(o);
        {x_a, x_b} = cx;
        {y_a, y_b} = cy;
        vx = cx[1]; px = (cx[1] == cx[0]);
        vy = cy[1]; py = (cy[1] == cy[0]);
        step();
        if (o == 3) tag = "R4";
        else if (px != py) tag = "R3";
        else begin
          tag = "R2";
          case (o)
            0: r = vx & vy;
            1: r = vx | vy;
            default: r = vx ^ vy;
          endcase
          model = tb_pair(r, px);
        end
        check_outputs(tag);
      end
    end

    // R6: reset wins over a consistent evaluation in the same cycle
    op = 2'b01; {x_a, x_b} = 2'b11; {y_a, y_b} = 2'b11; rst = 1'b1;
    step();
    model = 2'b01;
    check_outputs("R6");
    rst = 1'b0;
    step();
    model = 2'b11;
    check_outputs("R2");

    // R3: opcode change with mismatched phases keeps H
    op = 2'b00; {x_a, x_b} = 2'b00; {y_a, y_b} = 2'b10;
    step();
    check_outputs("R3");

    // R4: reserved opcode with consistent phase-0 inputs keeps H
    op = 2'b11; {x_a, x_b} = 2'b10; {y_a, y_b} = 2'b10;
    step();
    check_outputs("R4");

    // R2: XOR in phase 0 of h,h gives l
    op = 2'b10;
    step();
    model = 2'b01;
    check_outputs("R2");

    // R7: converter sweep
    for (int k = 0; k < 4; k++) begin
      plain_d = k[1];
      plain_ph = k[0];
      #1;
      chk("R7", {enc_a, enc_b}, tb_pair(k[1], k[0]));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule